// File: doc/BRIEF.md
# Counter-Timer Baud Clock Generator

This block turns the crystal clock into the 16x sample-enable pulses that the receivers and transmitters of up to two serial channels need. It contains one shared 16-bit down-counter that runs in square-wave mode. Software loads a preset as an upper and a lower byte. The counter is started and stopped by read accesses, not by writes. The counter only runs when an auxiliary control field selects timer mode. The square wave gives one tick per full period, so the 16x rate is the crystal clock divided by twice the preset. Each channel has a clock-select byte. Its two nibbles independently choose, for the receiver and for the transmitter, either the counter-timer output or one of thirteen fixed-rate taps. Each fixed-rate tap is a divider whose value comes from a parameter table. An auxiliary bit picks one of two such tables.

The timer is a two-state machine. Its states are `TMR_STOPPED` and `TMR_RUNNING`, and it has three transitions. START moves `TMR_STOPPED` to `TMR_RUNNING` and loads the preset. STOP moves `TMR_RUNNING` to `TMR_STOPPED` and holds the count. RESTART is a start read issued in `TMR_RUNNING`; it stays in `TMR_RUNNING` and reloads. While running with timer mode enabled, the counter counts down. At terminal count it reloads from the current preset and toggles the square wave, and every rising toggle emits one tick.

Top module: `baud_ctgen`

## Requirements
- R1: After reset every clock-select byte holds 0xFF and the timer is stopped, so no rx_tick or tx_tick pulse occurs.
- R2: With auxiliary bit 7 clear, fixed code c (0 to 12) makes the selected tick repeat every c+3 cycles (default table).
- R3: With auxiliary bit 7 set, fixed code c makes the selected tick repeat every 2*c+4 cycles (default table).
- R4: In a clock-select byte, bits 7:4 choose the receiver source and bits 3:0 the transmitter source, independently; channel n's byte is written at address 8*n+1.
- R5: Code 0xD routes the timer; while running in timer mode with preset P, its ticks repeat every 2*P cycles. The preset upper byte is written at address 6 and the lower byte at address 7.
- R6: A read of address 0xE starts the timer; the first timer tick appears P cycles after the clock edge that accepts the read.
- R7: A read of address 0xF stops the timer with no further timer ticks. The preset is kept, so a later start again gives first-tick latency P.
- R8: A preset written while the timer runs takes effect at the next reload; the tick spacing then becomes twice the new preset.
- R9: The timer counts only while auxiliary bits 6:4 equal 6 (auxiliary byte at address 4); with any other value no timer tick occurs.
- R10: A preset of 0 or 1 behaves as a preset of 2, so timer ticks repeat every 4 cycles.
- R11: Codes 0xE and 0xF select no source, and the corresponding tick stays low.
- R12: The two channels are independent: configuring channel 1 does not create ticks on channel 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Crystal clock, also the block clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Read strobe; only its side effects at 0xE and 0xF are used |
| bus_addr | input | 4 | Register address |
| bus_wdata | input | 8 | Write data |
| rx_tick | output | NUM_CH | Per-channel receiver 16x sample enable, one cycle wide |
| tx_tick | output | NUM_CH | Per-channel transmitter 16x sample enable, one cycle wide |

## Verification
The fixed taps are tried with codes from both ends and the middle of the table, under both table selections. Each pattern uses different receiver and transmitter codes, so a swapped nibble, a wrong table index or a mixed-up table shows up as a wrong period. The timer is tried with a mid-range preset, with a preset change while running and with presets below the legal minimum. These cases separate the first-tick latency from the steady spacing, show whether a reload picks up a new preset, and show whether the minimum is clamped. Stop/restart, mode-gating, idle-code and cross-channel patterns each expect a silent output, which exposes a tick that leaks from the wrong source.

// File: rtl/baud_ctgen_pkg.sv
package baud_ctgen_pkg;
    typedef enum logic {
        TMR_STOPPED = 1'b0,
        TMR_RUNNING = 1'b1
    } tmr_state_e;

    localparam int PRESET_W      = 16;
    localparam int FIXED_CODES   = 13;
    localparam int ADDR_W        = 4;

    localparam logic [3:0] SEL_TIMER  = 4'hD;
    localparam logic [2:0] MODE_TIMER = 3'd6;

    localparam logic [ADDR_W-1:0] ADR_AUX    = 4'h4;
    localparam logic [ADDR_W-1:0] ADR_PRE_HI = 4'h6;
    localparam logic [ADDR_W-1:0] ADR_PRE_LO = 4'h7;
    localparam logic [ADDR_W-1:0] ADR_START  = 4'hE;
    localparam logic [ADDR_W-1:0] ADR_STOP   = 4'hF;
    localparam logic [2:0]        CSEL_OFS   = 3'h1;
endpackage

// File: rtl/baud_ctgen_regs.sv
module baud_ctgen_regs
    import baud_ctgen_pkg::*;
#(
    parameter int NUM_CH = 2
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         bus_wr,
    input  logic                         bus_rd,
    input  logic [ADDR_W-1:0]            bus_addr,
    input  logic [7:0]                   bus_wdata,
    output logic [PRESET_W-1:0]          preset,
    output logic                         timer_en,
    output logic                         set_sel,
    output logic [NUM_CH-1:0][7:0]       csel,
    output logic [NUM_CH-1:0]            csel_wr,
    output logic                         start_cmd,
    output logic                         stop_cmd
);
    logic [7:0] aux_q;

    assign timer_en  = (aux_q[6:4] == MODE_TIMER);
    assign set_sel   = aux_q[7];
    assign start_cmd = bus_rd && (bus_addr == ADR_START);
    assign stop_cmd  = bus_rd && (bus_addr == ADR_STOP);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            aux_q  <= '0;
            preset <= '0;
        end else if (bus_wr) begin
            if (bus_addr == ADR_AUX)    aux_q         <= bus_wdata;
            if (bus_addr == ADR_PRE_HI) preset[15:8]  <= bus_wdata;
            if (bus_addr == ADR_PRE_LO) preset[7:0]   <= bus_wdata;
        end
    end

    for (genvar c = 0; c < NUM_CH; c++) begin : g_csel
        localparam logic [ADDR_W-1:0] CH_ADR = ADDR_W'(c * 8) | ADDR_W'(CSEL_OFS);
        assign csel_wr[c] = bus_wr && (bus_addr == CH_ADR);
        always_ff @(posedge clk) begin
            if (!rst_n)          csel[c] <= 8'hFF;
            else if (csel_wr[c]) csel[c] <= bus_wdata;
        end
    end
endmodule

// File: rtl/baud_ctgen_timer.sv
module baud_ctgen_timer
    import baud_ctgen_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start_cmd,
    input  logic                stop_cmd,
    input  logic                enable,
    input  logic [PRESET_W-1:0] preset,
    output logic                pulse,
    output logic                running
);
    tmr_state_e state_q, state_d;
    logic [PRESET_W-1:0] cnt_q;
    logic [PRESET_W-1:0] eff_preset;
    logic                sq_q;

    assign eff_preset = (preset < PRESET_W'(2)) ? PRESET_W'(2) : preset;
    assign running    = (state_q == TMR_RUNNING);

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= TMR_STOPPED;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            TMR_STOPPED: if (start_cmd) state_d = TMR_RUNNING;
            TMR_RUNNING: if (stop_cmd)  state_d = TMR_STOPPED;
            default:                    state_d = TMR_STOPPED;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
            sq_q  <= 1'b0;
            pulse <= 1'b0;
        end else begin
            pulse <= 1'b0;
            if (start_cmd) begin
                cnt_q <= eff_preset;
                sq_q  <= 1'b0;
            end else if (running && !stop_cmd && enable) begin
                if (cnt_q <= PRESET_W'(1)) begin
                    cnt_q <= eff_preset;
                    sq_q  <= ~sq_q;
                    pulse <= ~sq_q;
                end else begin
                    cnt_q <= cnt_q - PRESET_W'(1);
                end
            end
        end
    end
endmodule

// File: rtl/baud_ctgen_tap.sv
module baud_ctgen_tap
    import baud_ctgen_pkg::*;
#(
    parameter logic [FIXED_CODES-1:0][15:0] DIV_SET0 = '0,
    parameter logic [FIXED_CODES-1:0][15:0] DIV_SET1 = '0
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [3:0] sel,
    input  logic       set_sel,
    input  logic       restart,
    input  logic       timer_pulse,
    output logic       tick
);
    logic        is_fixed;
    logic [3:0]  idx;
    logic [15:0] div;
    logic [15:0] cnt_q;
    logic        hit;

    assign is_fixed = (sel < 4'(FIXED_CODES));
    assign idx      = is_fixed ? sel : 4'd0;
    assign div      = set_sel ? DIV_SET1[idx] : DIV_SET0[idx];
    assign hit      = is_fixed && (cnt_q >= div - 16'd1);
    assign tick     = hit || ((sel == SEL_TIMER) && timer_pulse);

    always_ff @(posedge clk) begin
        if (!rst_n || restart || !is_fixed) cnt_q <= '0;
        else if (hit)                       cnt_q <= '0;
        else                                cnt_q <= cnt_q + 16'd1;
    end
endmodule

// File: rtl/baud_ctgen.sv
module baud_ctgen
    import baud_ctgen_pkg::*;
#(
    parameter int NUM_CH = 2,
    parameter logic [FIXED_CODES-1:0][15:0] DIV_SET0 = {
        16'd15, 16'd14, 16'd13, 16'd12, 16'd11, 16'd10, 16'd9,
        16'd8,  16'd7,  16'd6,  16'd5,  16'd4,  16'd3},
    parameter logic [FIXED_CODES-1:0][15:0] DIV_SET1 = {
        16'd28, 16'd26, 16'd24, 16'd22, 16'd20, 16'd18, 16'd16,
        16'd14, 16'd12, 16'd10, 16'd8,  16'd6,  16'd4}
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [3:0]        bus_addr,
    input  logic [7:0]        bus_wdata,
    output logic [NUM_CH-1:0] rx_tick,
    output logic [NUM_CH-1:0] tx_tick
);
    logic [PRESET_W-1:0]    preset;
    logic                   timer_en;
    logic                   set_sel;
    logic [NUM_CH-1:0][7:0] csel;
    logic [NUM_CH-1:0]      csel_wr;
    logic                   start_cmd;
    logic                   stop_cmd;
    logic                   tmr_pulse;
    logic                   tmr_run;

    baud_ctgen_regs #(.NUM_CH(NUM_CH)) regs_i (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .preset(preset),
        .timer_en(timer_en), .set_sel(set_sel), .csel(csel),
        .csel_wr(csel_wr), .start_cmd(start_cmd), .stop_cmd(stop_cmd)
    );

    baud_ctgen_timer timer_i (
        .clk(clk), .rst_n(rst_n), .start_cmd(start_cmd), .stop_cmd(stop_cmd),
        .enable(timer_en), .preset(preset), .pulse(tmr_pulse), .running(tmr_run)
    );

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        baud_ctgen_tap #(.DIV_SET0(DIV_SET0), .DIV_SET1(DIV_SET1)) rx_tap_i (
            .clk(clk), .rst_n(rst_n), .sel(csel[c][7:4]), .set_sel(set_sel),
            .restart(csel_wr[c]), .timer_pulse(tmr_pulse), .tick(rx_tick[c])
        );
        baud_ctgen_tap #(.DIV_SET0(DIV_SET0), .DIV_SET1(DIV_SET1)) tx_tap_i (
            .clk(clk), .rst_n(rst_n), .sel(csel[c][3:0]), .set_sel(set_sel),
            .restart(csel_wr[c]), .timer_pulse(tmr_pulse), .tick(tx_tick[c])
        );
    end
endmodule

// File: rtl/baud_ctgen_chk.sv
module baud_ctgen_chk #(
    parameter int NUM_CH = 2
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   bus_rd,
    input logic [3:0]             bus_addr,
    input logic [NUM_CH-1:0]      rx_tick,
    input logic [NUM_CH-1:0]      tx_tick,
    input logic                   tmr_pulse,
    input logic                   tmr_run,
    input logic                   timer_en,
    input logic [NUM_CH-1:0][7:0] csel
);
    AST_PULSE_NEEDS_RUN: assert property (@(posedge clk) disable iff (!rst_n)
        tmr_pulse |-> $past(tmr_run)); // R5

    AST_STOP_SILENCES: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr == 4'hF) |=> !tmr_pulse); // R7

    AST_MODE_GATES: assert property (@(posedge clk) disable iff (!rst_n)
        !timer_en |=> !tmr_pulse); // R9

    for (genvar c = 0; c < NUM_CH; c++) begin : g_chk
        AST_RX_NO_REPEAT: assert property (@(posedge clk) disable iff (!rst_n)
            rx_tick[c] |=> !rx_tick[c] || $past(csel[c][7:4]) != csel[c][7:4]); // R2
        AST_TX_IDLE_CODE: assert property (@(posedge clk) disable iff (!rst_n)
            (csel[c][3:0] >= 4'hE) |-> !tx_tick[c]); // R11
        AST_RX_IDLE_CODE: assert property (@(posedge clk) disable iff (!rst_n)
            (csel[c][7:4] >= 4'hE) |-> !rx_tick[c]); // R11
    end
endmodule

bind baud_ctgen baud_ctgen_chk #(.NUM_CH(NUM_CH)) chk_i (
    .clk(clk), .rst_n(rst_n), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .rx_tick(rx_tick), .tx_tick(tx_tick), .tmr_pulse(tmr_pulse),
    .tmr_run(tmr_run), .timer_en(timer_en), .csel(csel)
);

// File: tb/baud_ctgen_tb_top.sv
`timescale 1ns/1ps
module baud_ctgen_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_wr = 1'b0;
    logic       bus_rd = 1'b0;
    logic [3:0] bus_addr = 4'h0;
    logic [7:0] bus_wdata = 8'h0;
    logic [1:0] rx_tick;
    logic [1:0] tx_tick;

    int errors = 0;
    int checks = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    baud_ctgen dut_i (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .rx_tick(rx_tick), .tx_tick(tx_tick)
    );

    // set, rx code, tx code, expected rx period, expected tx period
    localparam int NVEC = 6;
    localparam int VEC [NVEC][5] = '{
        '{0, 0, 12, 3, 15},
        '{1, 0, 12, 4, 28},
        '{0, 5, 7, 8, 10},
        '{1, 3, 1, 10, 6},
        '{0, 9, 9, 12, 12},
        '{1, 11, 6, 26, 16}
    };

    function automatic logic tick_at(input int idx);
        case (idx)
            0: return rx_tick[0];
            1: return tx_tick[0];
            2: return rx_tick[1];
            default: return tx_tick[1];
        endcase
    endfunction

    task automatic check_eq(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a);
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = a;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    // start read; returns negedge count until first tick on idx (1 = first negedge after accept edge)
    task automatic start_latency(input int idx, output int n);
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = 4'hE;
        @(negedge clk);
        bus_rd = 1'b0;
        n = 1;
        while (!tick_at(idx) && n < 5000) begin
            @(negedge clk);
            n++;
        end
    endtask

    task automatic period(input int idx, output int n);
        int w;
        w = 0;
        @(negedge clk);
        while (!tick_at(idx) && w < 5000) begin
            @(negedge clk);
            w++;
        end
        @(negedge clk);
        n = 1;
        while (!tick_at(idx) && n < 5000) begin
            @(negedge clk);
            n++;
        end
    endtask

    task automatic count_ticks(input int cycles, output int cnt);
        cnt = 0;
        for (int i = 0; i < cycles; i++) begin
            @(negedge clk);
            cnt += int'(rx_tick[0]) + int'(tx_tick[0]) + int'(rx_tick[1]) + int'(tx_tick[1]);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        int n;
        int c;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state silent
        count_ticks(60, c);
        check_eq("R1 reset ticks", c, 0);

        // R2 R3 R4: fixed taps, vector walk
        for (int v = 0; v < NVEC; v++) begin
            wr(4'h4, 8'(VEC[v][0] * 128 + 8'h60));
            wr(4'h1, 8'(VEC[v][1] * 16 + VEC[v][2]));
            period(0, n);
            check_eq(VEC[v][0] != 0 ? "R3 R4 rx period" : "R2 R4 rx period", n, VEC[v][3]);
            period(1, n);
            check_eq(VEC[v][0] != 0 ? "R3 R4 tx period" : "R2 R4 tx period", n, VEC[v][4]);
        end

        // R11: idle codes
        wr(4'h1, 8'hEF);
        count_ticks(100, c);
        check_eq("R11 idle codes", c, 0);

        // R5 R6: timer, preset 10
        wr(4'h4, 8'h60);
        wr(4'h6, 8'h00);
        wr(4'h7, 8'h0A);
        wr(4'h1, 8'hDD);
        start_latency(0, n);
        check_eq("R6 first tick latency", n, 11);
        period(0, n);
        check_eq("R5 timer rx period", n, 20);
        period(1, n);
        check_eq("R5 timer tx period", n, 20);

        // R8: preset change while running
        wr(4'h7, 8'h19);
        period(0, n);
        period(0, n);
        check_eq("R8 new preset period", n, 50);

        // R7: stop, then restart keeps preset
        rd(4'hF);
        count_ticks(200, c);
        check_eq("R7 stopped ticks", c, 0);
        start_latency(0, n);
        check_eq("R7 restart latency", n, 26);

        // R10: preset below minimum
        wr(4'h7, 8'h01);
        start_latency(0, n);
        period(0, n);
        check_eq("R10 clamped period", n, 4);
        wr(4'h7, 8'h00);
        period(0, n);
        period(0, n);
        check_eq("R10 zero preset period", n, 4);

        // R9: mode gating
        wr(4'h4, 8'h50);
        count_ticks(100, c);
        check_eq("R9 non-timer mode ticks", c, 0);
        wr(4'h4, 8'h60);
        period(0, n);
        check_eq("R9 resume period", n, 4);

        // R12: channel independence
        wr(4'h1, 8'hFF);
        wr(4'h9, 8'h2F);
        period(2, n);
        check_eq("R12 ch1 rx period", n, 5);
        c = 0;
        for (int i = 0; i < 100; i++) begin
            @(negedge clk);
            c += int'(rx_tick[0]) + int'(tx_tick[0]) + int'(tx_tick[1]);
        end
        check_eq("R12 other outputs silent", c, 0);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule